// File: doc/BRIEF.md
# Voltage-Window Power Sequencer Controller

This controller switches on four enable outputs, A, B, C and D in that order, once a monitored supply has stayed inside its voltage window for a programmable qualification time. Two comparator flags feed it: an undervoltage-good flag and an overvoltage flag. Each flag passes through its own deglitch filter before it is trusted. The block also takes a sequence-enable input and a power-on-reset input. All four delays are given in clock ticks: one start delay and one delay for each of the stages B, C and D.

Leaving the window at any moment drops every enable together. This holds during qualification, during the staged turn-on and after all four are on. Pulling sequence-enable low or raising power-on-reset has the same effect. The fault output reports whether the filtered supply is out of its window. A parameter selects active-high or active-low enables.

The state machine has six named states. ST_IDLE waits for the start condition. ST_QUAL times the start delay. ST_WAIT_B, ST_WAIT_C and ST_WAIT_D time the delays of B, C and D. ST_DONE holds all four enables on. The start condition is "go": the supply is compliant, sequence-enable is high and power-on-reset is low. The transitions are:
- start: ST_IDLE to ST_QUAL when go is true.
- advance: from each timing state to the next when its timer matches its delay and go still holds. ST_QUAL goes to ST_WAIT_B, ST_WAIT_B to ST_WAIT_C, ST_WAIT_C to ST_WAIT_D, and ST_WAIT_D to ST_DONE.
- abort: from any state other than ST_IDLE back to ST_IDLE when go falls.

Top module: `pwrseq_ctrl`

## Requirements
- R1: An enable becomes active only if the enable before it in the order A, B, C, D was already active in the previous cycle.
- R2: Sequencing starts only when all of the following hold in the same cycle: the filtered undervoltage-good is 1, the filtered overvoltage is 0, seq_en_i is 1 and por_i is 0.
- R3: Enable A becomes active start_dly_i+1 cycles after the start transition. A window violation during this time aborts the start and clears the timer, so a later start counts the full delay again.
- R4: Enables B, C and D each become active their own delay (dly_b_i, dly_c_i, dly_d_i) plus one cycle after the previous enable. A delay of zero gives the next cycle.
- R5: When the filtered supply leaves its window, every enable returns to its inactive level at the next clock edge. This applies during sequencing and after it has completed.
- R6: fault_o is 1 exactly when the filtered undervoltage-good is 0 or the filtered overvoltage is 1.
- R7: With ACTIVE_LOW=0, en_o bit i is 1 when stage i is active (bit 0 = A ... bit 3 = D). With ACTIVE_LOW=1, every bit is inverted, so the inactive level is 1.
- R8: While por_i is 1, all enables are inactive from the next edge on and no stage activates.
- R9: seq_en_i going low drops all enables at the next edge. Raising it again restarts from the start delay.
- R10: A change on uv_good_i or ov_flag_i takes effect only after it has held for FILT_TICKS consecutive cycles. A shorter pulse is ignored.
- R11: After reset, all enables are inactive and fault_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on-reset hold, active high |
| uv_good_i | input | 1 | Supply above its lower limit |
| ov_flag_i | input | 1 | Supply above its upper limit |
| seq_en_i | input | 1 | Sequence enable |
| start_dly_i | input | DLY_W | Qualification delay in ticks |
| dly_b_i | input | DLY_W | Delay from A to B |
| dly_c_i | input | DLY_W | Delay from B to C |
| dly_d_i | input | DLY_W | Delay from C to D |
| en_o | output | 4 | Enables, bit 0 = A |
| fault_o | output | 1 | Supply outside its window |

## Verification
Each enable edge is predicted as an exact cycle from the filter length and the delays. A state register that skips, repeats or stalls a stage therefore shows at en_o as an edge one or more cycles early or late, or as a missing edge. An abort path that leaves the timer uncleared shows as enable A arriving early after a restart. A state that fails to return to ST_IDLE shows as an enable still active one edge after a window violation, a por_i rise or a seq_en_i fall.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    localparam int unsigned NUM_EN = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_WAIT_B,
        ST_WAIT_C,
        ST_WAIT_D,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/pwrseq_deglitch.sv
module pwrseq_deglitch #(
    parameter int unsigned TICKS   = 4,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_o <= RST_VAL;
            cnt_q  <= '0;
        end else if (raw_i == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == LIM) begin
            filt_o <= raw_i;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the filtered value only ever moves toward the raw input
    assert_filter_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == limit_i);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned DLY_W      = 8,
    parameter int unsigned FILT_TICKS = 4,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_i,
    input  logic             uv_good_i,
    input  logic             ov_flag_i,
    input  logic             seq_en_i,
    input  logic [DLY_W-1:0] start_dly_i,
    input  logic [DLY_W-1:0] dly_b_i,
    input  logic [DLY_W-1:0] dly_c_i,
    input  logic [DLY_W-1:0] dly_d_i,
    output logic [3:0]       en_o,
    output logic             fault_o
);
    seq_state_t        state_q, state_d;
    logic              uv_f, ov_f, compliant, go;
    logic              tmr_clr, tmr_done;
    logic [DLY_W-1:0]  tmr_limit;
    logic [NUM_EN-1:0] act;

    pwrseq_deglitch #(.TICKS(FILT_TICKS), .RST_VAL(1'b0)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(uv_good_i), .filt_o(uv_f)
    );

    pwrseq_deglitch #(.TICKS(FILT_TICKS), .RST_VAL(1'b0)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(ov_flag_i), .filt_o(ov_f)
    );

    assign compliant = uv_f & ~ov_f;
    assign go        = compliant & seq_en_i & ~por_i;
    assign fault_o   = ~compliant;

    always_comb begin
        unique case (state_q)
            ST_QUAL:   tmr_limit = start_dly_i;
            ST_WAIT_B: tmr_limit = dly_b_i;
            ST_WAIT_C: tmr_limit = dly_c_i;
            ST_WAIT_D: tmr_limit = dly_d_i;
            default:   tmr_limit = '0;
        endcase
    end

    assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE);

    pwrseq_timer #(.W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .limit_i(tmr_limit), .done_o(tmr_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_QUAL;
            ST_QUAL:   if (!go) state_d = ST_IDLE; else if (tmr_done) state_d = ST_WAIT_B;
            ST_WAIT_B: if (!go) state_d = ST_IDLE; else if (tmr_done) state_d = ST_WAIT_C;
            ST_WAIT_C: if (!go) state_d = ST_IDLE; else if (tmr_done) state_d = ST_WAIT_D;
            ST_WAIT_D: if (!go) state_d = ST_IDLE; else if (tmr_done) state_d = ST_DONE;
            ST_DONE:   if (!go) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_WAIT_B: act = 4'b0001;
            ST_WAIT_C: act = 4'b0011;
            ST_WAIT_D: act = 4'b0111;
            ST_DONE:   act = 4'b1111;
            default:   act = 4'b0000;
        endcase
    end

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign en_o = ~act;
        end else begin : g_pol_high
            assign en_o = act;
        end
    endgenerate

    generate
        for (genvar i = 1; i < NUM_EN; i++) begin : g_order_chk
            assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(act[i]) |-> $past(act[i-1]));
        end
    endgenerate

    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act[0]) |-> $past(go));

    assert_window_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !compliant |=> (act == 4'b0000));

    assert_por_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (act == 4'b0000));

    assert_seq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en_i |=> (act == 4'b0000));
endmodule

// File: tb/pwrseq_ctrl_test.sv
`timescale 1ns/1ps
module pwrseq_ctrl_test;
    localparam int DW = 8;
    localparam int FT = 4;
    localparam int SD = 5;
    localparam int DB = 3;
    localparam int DC = 0;
    localparam int DD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por = 1'b0, uv = 1'b0, ov = 1'b0, sen = 1'b1;
    logic [DW-1:0] sd = DW'(SD), db = DW'(DB), dc = DW'(DC), dd = DW'(DD);
    logic [3:0] en_hi, en_lo;
    logic flt_hi, flt_lo;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int         qc[$];
    logic [3:0] qv[$];
    string      qt[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwrseq_ctrl #(.DLY_W(DW), .FILT_TICKS(FT), .ACTIVE_LOW(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .por_i(por), .uv_good_i(uv), .ov_flag_i(ov),
        .seq_en_i(sen), .start_dly_i(sd), .dly_b_i(db), .dly_c_i(dc),
        .dly_d_i(dd), .en_o(en_hi), .fault_o(flt_hi)
    );

    pwrseq_ctrl #(.DLY_W(DW), .FILT_TICKS(FT), .ACTIVE_LOW(1'b1)) uut_lo (
        .clk(clk), .rst_n(rst_n), .por_i(por), .uv_good_i(uv), .ov_flag_i(ov),
        .seq_en_i(sen), .start_dly_i(sd), .dly_b_i(db), .dly_c_i(dc),
        .dly_d_i(dd), .en_o(en_lo), .fault_o(flt_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [3:0] v, input string tag);
        qc.push_back(c);
        qv.push_back(v);
        qt.push_back(tag);
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // full turn-on expected when compliance (filtered) starts FT cycles after cycle n
    task automatic push_seq(input int n, input string tag);
        push(n + FT + SD + 2, 4'b0001, tag);
        push(n + FT + SD + DB + 3, 4'b0011, tag);
        push(n + FT + SD + DB + DC + 4, 4'b0111, tag);
        push(n + FT + SD + DB + DC + DD + 5, 4'b1111, tag);
    endtask

    // scoreboard monitor
    logic [3:0] prev_en = 4'b0000;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (en_hi !== prev_en) begin
                if (qc.size() == 0) begin
                    chk(1'b0, "R1 unexpected enable change", int'(en_hi), int'(prev_en));
                end else begin
                    int c;
                    logic [3:0] v;
                    string t;
                    c = qc.pop_front();
                    v = qv.pop_front();
                    t = qt.pop_front();
                    chk(en_hi === v, {t, " value"}, int'(en_hi), int'(v));
                    chk(cyc == c, {t, " cycle"}, cyc, c);
                end
                chk(en_lo === ~en_hi, "R7 inverted polarity", int'(en_lo), int'(~en_hi));
            end
            prev_en = en_hi;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int m, m2;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R11 reset state
        chk(en_hi == 4'b0000, "R11 enables inactive", int'(en_hi), 0);
        chk(flt_hi == 1'b1, "R11 fault after reset", int'(flt_hi), 1);
        chk(en_lo == 4'b1111, "R7 active-low reset level", int'(en_lo), 15);

        // R3 R4 R1: full turn-on
        m = cyc;
        uv = 1'b1;
        push_seq(m, "R4 sequence");
        wait_cyc(FT - 1);
        chk(flt_hi == 1'b1, "R10 fault before filter", int'(flt_hi), 1);
        wait_cyc(1);
        chk(flt_hi == 1'b0, "R6 fault clears", int'(flt_hi), 0);
        wait_cyc(25);
        chk(en_lo == 4'b0000, "R7 active-low all on", int'(en_lo), 0);

        // R5 overvoltage after completion
        m = cyc;
        ov = 1'b1;
        push(m + FT + 1, 4'b0000, "R5 drop after done");
        wait_cyc(10);
        chk(flt_hi == 1'b1, "R6 fault on overvoltage", int'(flt_hi), 1);

        // R10 short glitch ignored
        ov = 1'b0;
        wait_cyc(FT - 1);
        ov = 1'b1;
        wait_cyc(6);
        chk(flt_hi == 1'b1, "R10 glitch ignored fault", int'(flt_hi), 1);
        chk(en_hi == 4'b0000, "R10 glitch ignored enables", int'(en_hi), 0);
        m = cyc;
        ov = 1'b0;
        push_seq(m, "R10 filtered restart");
        wait_cyc(25);

        // R9 sequence-enable off and on
        m = cyc;
        sen = 1'b0;
        push(m + 1, 4'b0000, "R9 drop");
        wait_cyc(3);
        m2 = cyc;
        sen = 1'b1;
        push_seq(m2 - FT, "R9 restart");
        wait_cyc(20);

        // R8 power-on reset hold
        m = cyc;
        por = 1'b1;
        push(m + 1, 4'b0000, "R8 drop");
        wait_cyc(12);
        chk(en_hi == 4'b0000, "R8 held off", int'(en_hi), 0);
        m2 = cyc;
        por = 1'b0;
        push_seq(m2 - FT, "R8 release");
        wait_cyc(20);

        // R3 abort during qualification, then full delay again
        m = cyc;
        sen = 1'b0;
        push(m + 1, 4'b0000, "R9 drop");
        wait_cyc(2);
        sen = 1'b1;
        wait_cyc(1);
        uv = 1'b0;
        wait_cyc(6);
        chk(en_hi == 4'b0000, "R3 aborted start", int'(en_hi), 0);
        chk(flt_hi == 1'b1, "R6 fault on undervoltage", int'(flt_hi), 1);
        m = cyc;
        uv = 1'b1;
        push_seq(m, "R3 restart full delay");
        wait_cyc(25);

        // R5 violation mid-sequence; R2 no start while out of window
        m = cyc;
        sen = 1'b0;
        push(m + 1, 4'b0000, "R9 drop");
        wait_cyc(2);
        m2 = cyc;
        sen = 1'b1;
        push(m2 + SD + 2, 4'b0001, "R5 partial");
        push(m2 + SD + DB + 3, 4'b0011, "R5 partial");
        push(m2 + SD + DB + DC + 4, 4'b0111, "R4 zero delay");
        wait_cyc(8);
        ov = 1'b1;
        push(m2 + 8 + FT + 1, 4'b0000, "R5 drop mid-sequence");
        wait_cyc(15);
        chk(en_hi == 4'b0000, "R2 no start out of window", int'(en_hi), 0);
        m = cyc;
        ov = 1'b0;
        push_seq(m, "R2 start when compliant");
        wait_cyc(25);

        chk(qc.size() == 0, "R1 all expected edges seen", qc.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule